// File: doc/BRIEF.md
# Ping-Pong Write Buffer Controller

This block sits between a bus-side write port and an SDRAM write port. It takes write beats (address plus data) from the bus into one of two small buffers. When a buffer is closed, it empties toward the SDRAM side, one entry per accepted beat. The other buffer keeps taking bus writes at the same time, so bus filling and SDRAM draining overlap.

A buffer closes in two cases: when its last slot is written, or when the bus offers no write for a cycle after at least one beat has arrived. Only one buffer drains at a time. Once a buffer starts draining, it empties completely before it can be filled again. The bus is stalled only when both buffers are closed or draining.

Top module: `pwb_pingpong`

## Requirements
- R1: A buffer that has been partly filled and is still open keeps receiving beats. If neither buffer is open, beats go to buffer 0 when it is empty, and otherwise to buffer 1 when that one is empty.
- R2: An open buffer closes on the clock edge that accepts its DEPTH-th beat. It also closes on the first edge at which `in_valid` is low.
- R3: `in_ready` is high exactly when at least one buffer is empty or open. A beat is taken only on an edge where `in_valid` and `in_ready` are both high.
- R4: A closed buffer starts draining on the first edge at which no buffer is draining. `dr_valid` is high from the following cycle onward.
- R5: While draining, the block shows the buffer's entries in write order on `dr_addr`/`dr_data`. It holds each entry until `dr_accept` is high. The buffer becomes empty on the edge that accepts its last entry.
- R6: At most one buffer drains at a time. A closed buffer waits for the other to finish draining.
- R7: In a cycle where `dr_valid` is high, the bus side still accepts a beat if `in_ready` is high.
- R8: Every accepted beat leaves on the drain port exactly once, in the order it was accepted.
- R9: After reset both buffers are empty, `in_ready` is 1 and `dr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Bus offers a write beat; low marks the end of a write sequence |
| in_addr | input | AW | Address of the offered beat |
| in_data | input | DW | Data of the offered beat |
| in_ready | output | 1 | Block can take a beat this cycle; low stalls the bus |
| dr_valid | output | 1 | A drain entry is presented |
| dr_addr | output | AW | Address of the presented entry |
| dr_data | output | DW | Data of the presented entry |
| dr_accept | input | 1 | SDRAM side takes the presented entry |

## Verification
Every result of this block follows a single register stage, so each one is due in the cycle after the edge that acts on the stimulus. A beat accepted at one edge sets `in_ready` for the next cycle. A buffer that closes at an edge raises `dr_valid` one edge later. A `dr_accept` moves the drain head, or frees the buffer, at that same edge. The bench applies each cycle's inputs to a queue-based reference model at the falling edge. It then compares `in_ready`, `dr_valid` and the drain head at the next falling edge, halfway after the rising edge where the design updates.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    // Lifecycle of one buffer; values only matter inside this block
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_OPEN  = 2'd1,
        SLOT_WAIT  = 2'd2,
        SLOT_DRAIN = 2'd3
    } slot_state_e;
endpackage

// File: rtl/pwb_slot.sv
module pwb_slot
    import pwb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          seq_end,
    input  logic          drain_go,
    input  logic          pop,
    output slot_state_e   state_o,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        slot_state_e                st;
        logic [CW-1:0]              cnt;
        logic [PW-1:0]              rptr;
        logic [DEPTH-1:0][AW-1:0]   addr;
        logic [DEPTH-1:0][DW-1:0]   data;
    } slot_t;

    slot_t r_d, r_q;
    logic  fills_last;
    logic  pops_last;

    always_comb begin
        r_d        = r_q;
        fills_last = (r_q.cnt + CW'(1)) == CW'(DEPTH);
        pops_last  = (CW'(r_q.rptr) + CW'(1)) == r_q.cnt;
        unique case (r_q.st)
            SLOT_EMPTY, SLOT_OPEN: begin
                if (wr_en) begin
                    r_d.addr[r_q.cnt[PW-1:0]] = wr_addr;
                    r_d.data[r_q.cnt[PW-1:0]] = wr_data;
                    r_d.cnt = r_q.cnt + CW'(1);
                    r_d.st  = fills_last ? SLOT_WAIT : SLOT_OPEN;
                end else if (r_q.st == SLOT_OPEN && seq_end) begin
                    r_d.st = SLOT_WAIT;
                end
            end
            SLOT_WAIT: begin
                if (drain_go) begin
                    r_d.st   = SLOT_DRAIN;
                    r_d.rptr = '0;
                end
            end
            SLOT_DRAIN: begin
                if (pop) begin
                    if (pops_last) begin
                        r_d.st   = SLOT_EMPTY;
                        r_d.cnt  = '0;
                        r_d.rptr = '0;
                    end else begin
                        r_d.rptr = r_q.rptr + PW'(1);
                    end
                end
            end
            default: r_d.st = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign state_o   = r_q.st;
    assign head_addr = r_q.addr[r_q.rptr];
    assign head_data = r_q.data[r_q.rptr];

    // R2: writes only land in an empty or open buffer
    p_fill_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (r_q.st == SLOT_EMPTY || r_q.st == SLOT_OPEN));
    // R2: the DEPTH-th beat closes the buffer
    p_close_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fills_last) |=> (r_q.st == SLOT_WAIT));
    // R5: without a pop the drain head does not move
    p_head_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SLOT_DRAIN && !pop) |=> (r_q.st == SLOT_DRAIN && $stable(r_q.rptr)));
    // R5: a drain ends with the buffer empty
    p_drain_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SLOT_DRAIN && pop && pops_last) |=> (r_q.st == SLOT_EMPTY && r_q.cnt == '0));
endmodule

// File: rtl/pwb_fill_sel.sv
module pwb_fill_sel
    import pwb_pkg::*;
(
    input  slot_state_e st0,
    input  slot_state_e st1,
    input  logic        in_valid,
    output logic        ready,
    output logic [1:0]  wr_en
);
    logic to_one;

    always_comb begin
        // an open buffer keeps the sequence; else empty 0, else empty 1
        to_one = (st1 == SLOT_OPEN) ||
                 (st0 != SLOT_OPEN && st0 != SLOT_EMPTY && st1 == SLOT_EMPTY);
        ready  = (st0 == SLOT_EMPTY) || (st0 == SLOT_OPEN) ||
                 (st1 == SLOT_EMPTY) || (st1 == SLOT_OPEN);
        wr_en[0] = in_valid && ready && !to_one;
        wr_en[1] = in_valid && ready && to_one;
    end
endmodule

// File: rtl/pwb_drain_arb.sv
module pwb_drain_arb
    import pwb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  slot_state_e   st0,
    input  slot_state_e   st1,
    input  logic          dr_accept,
    input  logic [AW-1:0] head_addr0,
    input  logic [DW-1:0] head_data0,
    input  logic [AW-1:0] head_addr1,
    input  logic [DW-1:0] head_data1,
    output logic [1:0]    drain_go,
    output logic [1:0]    pop,
    output logic          dr_valid,
    output logic [AW-1:0] dr_addr,
    output logic [DW-1:0] dr_data
);
    logic busy0, busy1;

    always_comb begin
        busy0       = (st0 == SLOT_DRAIN);
        busy1       = (st1 == SLOT_DRAIN);
        drain_go[0] = !busy0 && !busy1 && (st0 == SLOT_WAIT);
        drain_go[1] = !busy0 && !busy1 && (st1 == SLOT_WAIT) && (st0 != SLOT_WAIT);
        dr_valid    = busy0 || busy1;
        pop[0]      = busy0 && dr_accept;
        pop[1]      = busy1 && dr_accept;
        dr_addr     = busy1 ? head_addr1 : head_addr0;
        dr_data     = busy1 ? head_data1 : head_data0;
    end
endmodule

// File: rtl/pwb_pingpong.sv
module pwb_pingpong
    import pwb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          dr_valid,
    output logic [AW-1:0] dr_addr,
    output logic [DW-1:0] dr_data,
    input  logic          dr_accept
);
    localparam int NBUF = 2;

    slot_state_e          st [NBUF];
    logic [NBUF-1:0]      wr_en;
    logic [NBUF-1:0]      drain_go;
    logic [NBUF-1:0]      pop;
    logic [AW-1:0]        head_addr [NBUF];
    logic [DW-1:0]        head_data [NBUF];

    pwb_fill_sel u_fill (
        .st0      (st[0]),
        .st1      (st[1]),
        .in_valid (in_valid),
        .ready    (in_ready),
        .wr_en    (wr_en)
    );

    for (genvar i = 0; i < NBUF; i++) begin : g_slot
        pwb_slot #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en[i]),
            .wr_addr   (in_addr),
            .wr_data   (in_data),
            .seq_end   (!in_valid),
            .drain_go  (drain_go[i]),
            .pop       (pop[i]),
            .state_o   (st[i]),
            .head_addr (head_addr[i]),
            .head_data (head_data[i])
        );
    end

    pwb_drain_arb #(.AW(AW), .DW(DW)) u_arb (
        .st0        (st[0]),
        .st1        (st[1]),
        .dr_accept  (dr_accept),
        .head_addr0 (head_addr[0]),
        .head_data0 (head_data[0]),
        .head_addr1 (head_addr[1]),
        .head_data1 (head_data[1]),
        .drain_go   (drain_go),
        .pop        (pop),
        .dr_valid   (dr_valid),
        .dr_addr    (dr_addr),
        .dr_data    (dr_data)
    );

    // R6: never two drains at once
    p_one_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(st[0] == SLOT_DRAIN && st[1] == SLOT_DRAIN));
    // R3: a stall means no buffer can take a beat
    p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (st[0] inside {SLOT_WAIT, SLOT_DRAIN} && st[1] inside {SLOT_WAIT, SLOT_DRAIN}));
    // R1: an open buffer 1 takes the next beat
    p_keep_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && st[1] == SLOT_OPEN) |-> (wr_en == 2'b10));
    // R4: a waiting buffer 0 with no drain in progress starts draining
    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st[0] == SLOT_WAIT && st[1] != SLOT_DRAIN) |=> (st[0] == SLOT_DRAIN));
    // R5: a presented entry holds until accepted
    p_dr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_valid && !dr_accept) |=> (dr_valid && $stable(dr_addr) && $stable(dr_data)));
endmodule

// File: tb/pwb_pingpong_tb.sv
module pwb_pingpong_tb;
    localparam int DEPTH = 4;
    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int EW    = AW + DW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [AW-1:0] in_addr;
    logic [DW-1:0] in_data;
    logic          in_ready;
    logic          dr_valid;
    logic [AW-1:0] dr_addr;
    logic [DW-1:0] dr_data;
    logic          dr_accept;

    always #10 clk = ~clk;

    pwb_pingpong #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_data(in_data), .in_ready(in_ready), .dr_valid(dr_valid),
        .dr_addr(dr_addr), .dr_data(dr_data), .dr_accept(dr_accept)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: phase 0 empty, 1 open, 2 closed, 3 draining
    int             ph  [2];
    int             cnt [2];
    int             idx [2];
    logic [EW-1:0]  ent [2][DEPTH];
    logic [EW-1:0]  order_q [$];
    int             seq = 0;
    int             overlap = 0;
    int             stalls  = 0;

    function automatic int draining();
        if (ph[0] == 3) return 0;
        if (ph[1] == 3) return 1;
        return -1;
    endfunction

    task automatic compare_outputs();
        bit            er;
        int            d;
        logic [EW-1:0] head;
        er = (ph[0] <= 1) || (ph[1] <= 1);
        d  = draining();
        chk(in_ready == er, "R3 R1 R9 in_ready", 64'(in_ready), 64'(er));
        chk(dr_valid == (d >= 0), "R4 R2 R6 dr_valid", 64'(dr_valid), 64'(d >= 0));
        if (d >= 0 && dr_valid) begin
            head = ent[d][idx[d]];
            chk({dr_addr, dr_data} == head, "R5 R1 drain head", 64'({dr_addr, dr_data}), 64'(head));
        end
    endtask

    task automatic step_model(input bit v, input bit acc);
        int            tgt;
        int            d;
        int            nph [2];
        logic [EW-1:0] beat;
        nph = ph;
        d   = draining();
        if (ph[1] == 1)      tgt = 1;
        else if (ph[0] == 1) tgt = 0;
        else if (ph[0] == 0) tgt = 0;
        else if (ph[1] == 0) tgt = 1;
        else                 tgt = -1;
        if (v && tgt < 0) stalls++;
        if (v && tgt >= 0 && d >= 0 && acc) overlap++;
        // drain side
        if (d >= 0 && acc) begin
            beat = ent[d][idx[d]];
            if (order_q.size() == 0) begin
                chk(1'b0, "R8 drained beat never written", 64'({dr_addr, dr_data}), 64'(0));
            end else begin
                chk({dr_addr, dr_data} == order_q[0], "R8 drain order",
                    64'({dr_addr, dr_data}), 64'(order_q[0]));
                void'(order_q.pop_front());
            end
            idx[d]++;
            if (idx[d] == cnt[d]) begin
                nph[d] = 0; cnt[d] = 0; idx[d] = 0;
            end
        end
        if (d < 0) begin
            if (ph[0] == 2)      begin nph[0] = 3; idx[0] = 0; end
            else if (ph[1] == 2) begin nph[1] = 3; idx[1] = 0; end
        end
        // fill side
        if (v && tgt >= 0) begin
            beat = {in_addr, in_data};
            ent[tgt][cnt[tgt]] = beat;
            cnt[tgt]++;
            order_q.push_back(beat);
            seq++;
            nph[tgt] = (cnt[tgt] == DEPTH) ? 2 : 1;
        end else if (!v) begin
            for (int b = 0; b < 2; b++) if (ph[b] == 1) nph[b] = 2;
        end
        ph = nph;
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_data = '0; dr_accept = 1'b0;
        for (int b = 0; b < 2; b++) begin ph[b] = 0; cnt[b] = 0; idx[b] = 0; end
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(in_ready == 1'b1, "R9 reset in_ready", 64'(in_ready), 64'(1));
        chk(dr_valid == 1'b0, "R9 reset dr_valid", 64'(dr_valid), 64'(0));
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 1500; cyc++) begin
            bit v, acc;
            @(negedge clk);
            compare_outputs();
            if (cyc < 6)         begin v = 0; acc = 1; end
            else if (cyc < 60)   begin v = 1; acc = 1; end          // streaming
            else if (cyc < 120)  begin v = (cyc % 3 != 0); acc = 1; end  // short sequences, R2
            else if (cyc < 170)  begin v = 1; acc = 0; end          // stall, R3 R6
            else if (cyc < 200)  begin v = 1; acc = (cyc % 2 == 0); end
            else if (cyc < 1450) begin v = ($urandom % 4 != 0); acc = ($urandom % 3 != 0); end
            else                 begin v = 0; acc = 1; end          // flush
            in_valid  = v;
            in_addr   = AW'(seq);
            in_data   = DW'(seq) * 32'h9E37_79B1;
            dr_accept = acc;
            step_model(v, acc);
        end
        @(negedge clk);
        compare_outputs();
        chk(stalls > 0, "R3 stall observed", 64'(stalls), 64'(1));
        chk(overlap > 0, "R7 fill during drain", 64'(overlap), 64'(1));
        chk(order_q.size() == 0, "R8 all beats drained", 64'(order_q.size()), 64'(0));
        chk(in_ready == 1'b1 && dr_valid == 1'b0, "R5 idle after flush",
            64'({in_ready, dr_valid}), 64'(2));
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule